// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the three status flags of an asynchronous serial port: transmit holding register empty, receive holding register full, and receive overrun. It also holds the byte waiting to be shifted out and the last byte received. Software reaches the status register and both holding registers through a small register port. The transmitter and receiver cores talk to it through single-cycle event strobes. The serial shifters, baud timing, framing and parity checks are outside the block.

A flag that hardware has raised can only be dropped by software in two steps. First a status read has to return that flag as 1. Then a later write has to put 0 in that flag's bit. A received frame that arrives while the previous byte is still unread raises the overrun flag and is thrown away. The stored byte stays as it was. While overrun is up, every further completed frame is ignored.

Top module: `sio_flag_ctrl`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0 and rx_overrun is 0. Both holding registers read 0. Status bits 4 down to 0 always read 0.
- R2: Register selection uses bus_addr. Address 0 is status, with tx_empty on bit 7, rx_full on bit 6 and rx_overrun on bit 5. Address 1 is the transmit holding register, address 2 is the receive holding register, and address 3 reads 0. Reading address 2 changes no flag.
- R3: A status read (bus_rd with address 0) arms each flag that reads 1. A later status write with 0 in that flag's bit clears the flag only if it is armed. Every status write disarms all three flags. Writing 1 to a flag bit has no effect.
- R4: If a hardware set event and an armed software clear reach the same flag in the same cycle, the flag stays 1.
- R5: A write to address 1 loads the transmit holding register only while tx_empty is 0. Otherwise the write is ignored. tx_data always shows the register.
- R6: tx_empty is 1 in the cycle after tx_load, and in the cycle after any cycle with tx_en low.
- R7: rx_done with rx_en high, rx_err low, rx_full 0 and rx_overrun 0 has two effects in the next cycle: rx_data appears in the receive holding register and rx_full is 1.
- R8: A frame accepted under the conditions of R7, except that rx_full is 1, sets rx_overrun. The receive holding register keeps its old byte.
- R9: While rx_overrun is 1, rx_done changes neither rx_full nor the receive holding register, even when rx_full is 0.
- R10: rx_done is ignored while rx_en is low or rx_err is high. Dropping rx_en leaves both receive flags and the receive holding register unchanged.
- R11: A cycle with standby high returns all three flags to their reset values and disarms them. Neither holding register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Standby request, resets the flags |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| tx_load | input | 1 | Transmitter moved the holding byte into its shifter |
| tx_data | output | 8 | Transmit holding register |
| rx_done | input | 1 | Receiver completed a frame |
| rx_err | input | 1 | The frame completed this cycle has an error |
| rx_data | input | 8 | Byte of the completed frame |
| tx_empty | output | 1 | Transmit holding register empty flag |
| rx_full | output | 1 | Receive holding register full flag |
| rx_overrun | output | 1 | Receive overrun flag |

## Verification
The assertions assume that the transmitter raises tx_load only while tx_empty is 0. One assertion watches this contract at the input. The assertions also assume that a read and a write never share a cycle. The stimulus follows both rules. tx_load is driven only after a stimulus step has left tx_empty at 0, and every step carries a single bus operation. The vector walk and the directed tests cover these cases: a set and a clear meeting in the same cycle, frames during overrun, frames with rx_en low or rx_err high, and standby.

// File: rtl/sio_flag_pkg.sv
package sio_flag_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int NFLAG  = 3;

    // flag index i sits at status bit DATA_W-1-i
    localparam int FL_TXE = 0;
    localparam int FL_RXF = 1;
    localparam int FL_OVR = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STAT = 2'd0,
        SEL_TXH  = 2'd1,
        SEL_RXH  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic flag;
        logic arm;
    } cell_st_t;
endpackage

// File: rtl/sio_flag_cell.sv
module sio_flag_cell
    import sio_flag_pkg::*;
#(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic set_evt,
    input  logic rd_stat,
    input  logic wr_stat,
    input  logic wr_bit,
    output logic flag_o
);
    cell_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_stat && st_q.flag) begin
            st_d.arm = 1'b1;
        end
        if (wr_stat) begin
            if (!wr_bit && st_q.arm) begin
                st_d.flag = 1'b0;
            end
            st_d.arm = 1'b0;
        end
        if (set_evt) begin
            st_d.flag = 1'b1;
        end
        if (init) begin
            st_d.flag = INIT;
            st_d.arm  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: INIT, arm: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !init) |=> flag_o);

    // R3
    no_unarmed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !st_q.arm && !init) |=> st_q.flag);

    // R11
    init_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (st_q.flag == INIT) && !st_q.arm);
endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold
    import sio_flag_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          tx_en,
    input  logic          tx_load,
    input  logic          wr_txh,
    input  logic [DW-1:0] wdata,
    input  logic          empty_q,
    output logic          set_empty,
    output logic [DW-1:0] hold_o
);
    logic [DW-1:0] hold_d, hold_q;

    always_comb begin
        hold_d    = hold_q;
        set_empty = tx_load || !tx_en || standby;
        if (wr_txh && !empty_q) begin
            hold_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign hold_o = hold_q;

    // R5
    tx_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txh && empty_q) |=> $stable(hold_o));

    // R5
    tx_write_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txh && !empty_q) |=> (hold_o == $past(wdata)));

    // R6
    tx_load_contract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> !empty_q);
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold
    import sio_flag_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          rx_en,
    input  logic          rx_done,
    input  logic          rx_err,
    input  logic [DW-1:0] rx_data,
    input  logic          full_q,
    input  logic          ovr_q,
    output logic          set_full,
    output logic          set_ovr,
    output logic [DW-1:0] hold_o
);
    logic [DW-1:0] hold_d, hold_q;
    logic          frame_ok;

    always_comb begin
        frame_ok = rx_done && !rx_err && rx_en && !standby && !ovr_q;
        set_full = frame_ok && !full_q;
        set_ovr  = frame_ok && full_q;
        hold_d   = hold_q;
        if (set_full) begin
            hold_d = rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign hold_o = hold_q;

    // R9
    ovr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> $stable(hold_o));

    // R8
    full_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |=> $stable(hold_o));

    // R7
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_en && !rx_err && !standby && !full_q && !ovr_q)
        |=> (hold_o == $past(rx_data)));

    // R10
    rx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en || rx_err) |=> $stable(hold_o));
endmodule

// File: rtl/sio_flag_ctrl.sv
module sio_flag_ctrl
    import sio_flag_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          tx_en,
    input  logic          rx_en,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tx_load,
    output logic [DW-1:0] tx_data,
    input  logic          rx_done,
    input  logic          rx_err,
    input  logic [DW-1:0] rx_data,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          rx_overrun
);
    localparam int PAD_W = DW - NFLAG;

    logic             rd_stat, wr_stat, wr_txh;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flag_vec;
    logic [NFLAG-1:0] stat_bits;
    logic [DW-1:0]    rx_hold;

    always_comb begin
        rd_stat = bus_rd && !bus_wr && (bus_addr == SEL_STAT);
        wr_stat = bus_wr && (bus_addr == SEL_STAT);
        wr_txh  = bus_wr && (bus_addr == SEL_TXH);
    end

    sio_tx_hold #(.DW(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .tx_en     (tx_en),
        .tx_load   (tx_load),
        .wr_txh    (wr_txh),
        .wdata     (bus_wdata),
        .empty_q   (flag_vec[FL_TXE]),
        .set_empty (set_vec[FL_TXE]),
        .hold_o    (tx_data)
    );

    sio_rx_hold #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .rx_en    (rx_en),
        .rx_done  (rx_done),
        .rx_err   (rx_err),
        .rx_data  (rx_data),
        .full_q   (flag_vec[FL_RXF]),
        .ovr_q    (flag_vec[FL_OVR]),
        .set_full (set_vec[FL_RXF]),
        .set_ovr  (set_vec[FL_OVR]),
        .hold_o   (rx_hold)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        sio_flag_cell #(.INIT(i == FL_TXE)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .init    (standby),
            .set_evt (set_vec[i]),
            .rd_stat (rd_stat),
            .wr_stat (wr_stat),
            .wr_bit  (bus_wdata[DW-1-i]),
            .flag_o  (flag_vec[i])
        );
        assign stat_bits[NFLAG-1-i] = flag_vec[i];
    end

    assign tx_empty   = flag_vec[FL_TXE];
    assign rx_full    = flag_vec[FL_RXF];
    assign rx_overrun = flag_vec[FL_OVR];

    always_comb begin
        unique case (bus_addr)
            SEL_STAT: bus_rdata = {stat_bits, {PAD_W{1'b0}}};
            SEL_TXH:  bus_rdata = tx_data;
            SEL_RXH:  bus_rdata = rx_hold;
            default:  bus_rdata = '0;
        endcase
    end

    // R6
    tx_load_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> tx_empty);

    // R11
    standby_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (tx_empty && !rx_full && !rx_overrun));

    // R10
    rx_off_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !bus_wr && !standby) |=> ($stable(rx_full) && $stable(rx_overrun)));

    // R9
    ovr_blocks_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_full && !standby) |=> !rx_full);
endmodule

// File: tb/sio_flag_ctrl_bench.sv
module sio_flag_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       tx_en = 1'b1;
    logic       rx_en = 1'b1;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data;
    logic       rx_done = 1'b0;
    logic       rx_err = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_empty, rx_full, rx_overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sio_flag_ctrl u_sio_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .standby(standby), .tx_en(tx_en), .rx_en(rx_en),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_load(tx_load), .tx_data(tx_data),
        .rx_done(rx_done), .rx_err(rx_err), .rx_data(rx_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .rx_overrun(rx_overrun)
    );

    // {op(0 idle,1 read,2 write), addr, wdata, tx_load, rx_done, rx_err, rx_data,
    //  expected read data, expected flags {tx_empty, rx_full, rx_overrun}}
    localparam int NV = 23;
    localparam logic [33:0] VEC [NV] = '{
        {2'd1, 2'd0, 8'h00, 3'b000, 8'h00, 8'h80, 3'b100},
        {2'd2, 2'd0, 8'h00, 3'b000, 8'h00, 8'h00, 3'b000},
        {2'd2, 2'd1, 8'h5A, 3'b000, 8'h00, 8'h00, 3'b000},
        {2'd1, 2'd1, 8'h00, 3'b000, 8'h00, 8'h5A, 3'b000},
        {2'd0, 2'd0, 8'h00, 3'b100, 8'h00, 8'h00, 3'b100},
        {2'd2, 2'd1, 8'h33, 3'b000, 8'h00, 8'h00, 3'b100},
        {2'd1, 2'd1, 8'h00, 3'b000, 8'h00, 8'h5A, 3'b100},
        {2'd0, 2'd0, 8'h00, 3'b010, 8'hC3, 8'h00, 3'b110},
        {2'd1, 2'd2, 8'h00, 3'b000, 8'h00, 8'hC3, 3'b110},
        {2'd2, 2'd0, 8'h00, 3'b000, 8'h00, 8'h00, 3'b110},
        {2'd0, 2'd0, 8'h00, 3'b010, 8'h11, 8'h00, 3'b111},
        {2'd1, 2'd2, 8'h00, 3'b000, 8'h00, 8'hC3, 3'b111},
        {2'd1, 2'd0, 8'h00, 3'b000, 8'h00, 8'hE0, 3'b111},
        {2'd2, 2'd0, 8'hDF, 3'b000, 8'h00, 8'h00, 3'b110},
        {2'd2, 2'd0, 8'h00, 3'b000, 8'h00, 8'h00, 3'b110},
        {2'd1, 2'd0, 8'h00, 3'b000, 8'h00, 8'hC0, 3'b110},
        {2'd2, 2'd0, 8'h80, 3'b010, 8'h22, 8'h00, 3'b101},
        {2'd0, 2'd0, 8'h00, 3'b010, 8'h44, 8'h00, 3'b101},
        {2'd1, 2'd2, 8'h00, 3'b000, 8'h00, 8'hC3, 3'b101},
        {2'd1, 2'd0, 8'h00, 3'b000, 8'h00, 8'hA0, 3'b101},
        {2'd2, 2'd0, 8'h00, 3'b000, 8'h00, 8'h00, 3'b000},
        {2'd0, 2'd0, 8'h00, 3'b010, 8'h66, 8'h00, 3'b010},
        {2'd1, 2'd0, 8'h00, 3'b000, 8'h00, 8'h40, 3'b010}
    };

    function automatic string vec_tag(int idx);
        case (idx)
            0, 1, 9, 12, 13, 14, 15, 19, 20, 22: return "R3";
            2, 3, 5, 6:                          return "R5";
            4:                                   return "R6";
            7, 8, 21:                            return "R7";
            10, 11, 16:                          return "R8";
            default:                             return "R9";
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] flags();
        return {5'b0, tx_empty, rx_full, rx_overrun};
    endfunction

    // drive one cycle at a falling edge, check read data before the rising edge,
    // check flags at the next falling edge
    task automatic step(logic [1:0] op, logic [1:0] addr, logic [7:0] wd,
                        logic txl, logic rxd, logic rxe, logic [7:0] rdat,
                        logic [7:0] exp_rd, logic [2:0] exp_fl, string req);
        bus_rd    = (op == 2'd1);
        bus_wr    = (op == 2'd2);
        bus_addr  = addr;
        bus_wdata = wd;
        tx_load   = txl;
        rx_done   = rxd;
        rx_err    = rxe;
        rx_data   = rdat;
        #1;
        if (op == 2'd1) chk(req, bus_rdata, exp_rd);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; tx_load = 1'b0; rx_done = 1'b0; rx_err = 1'b0;
        chk(req, flags(), {5'b0, exp_fl});
    endtask

    task automatic rd_only(logic [1:0] addr, logic [7:0] exp, string req);
        bus_addr = addr;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", flags(), 8'h04);
        rd_only(2'd0, 8'h80, "R1");
        rd_only(2'd1, 8'h00, "R1");
        rd_only(2'd2, 8'h00, "R1");
        chk("R1", tx_data, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][33:32], VEC[i][31:30], VEC[i][29:22], VEC[i][21], VEC[i][20],
                 VEC[i][19], VEC[i][18:11], VEC[i][10:3], VEC[i][2:0], vec_tag(i));
        end
        // state: empty 0, full 1 (armed), overrun 0, tx 5A, rx 66

        // R6 load to shifter raises empty
        step(2'd0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 3'b110, "R6");
        chk("R5", tx_data, 8'h5A);

        // R4 armed clear of empty meets tx_en low in the same cycle
        step(2'd1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC0, 3'b110, "R4");
        tx_en = 1'b0;
        step(2'd2, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'b100, "R4");
        tx_en = 1'b1;
        step(2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'b100, "R4");

        // R6 tx_en low forces empty
        step(2'd1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80, 3'b100, "R6");
        step(2'd2, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'b000, "R6");
        tx_en = 1'b0;
        step(2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'b100, "R6");
        tx_en = 1'b1;

        // R10 receiver disabled, then an errored frame
        rx_en = 1'b0;
        step(2'd0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h77, 8'h00, 3'b100, "R10");
        rx_en = 1'b1;
        rd_only(2'd2, 8'h66, "R10");
        step(2'd0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h99, 8'h00, 3'b100, "R10");
        rd_only(2'd2, 8'h66, "R10");
        step(2'd0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h88, 8'h00, 3'b110, "R7");
        rd_only(2'd2, 8'h88, "R7");

        // R11 standby resets flags and arms, keeps data
        step(2'd1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC0, 3'b110, "R11");
        standby = 1'b1;
        step(2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'b100, "R11");
        standby = 1'b0;
        step(2'd2, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'b100, "R11");
        rd_only(2'd2, 8'h88, "R11");
        rd_only(2'd1, 8'h5A, "R11");

        // R2 unused address
        rd_only(2'd3, 8'h00, "R2");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule